// File: doc/BRIEF.md
# Serial Receive Queue with Character Timeout

This block holds the bytes a serial receiver has assembled until the host bus reads them. It is a sixteen-entry circular queue with a selectable fill threshold, a control-register write path whose side effects include flushing the receive queue and pulsing a flush request toward the transmit side, and a timer that flags data left unread for four character times. When the queue is switched off through the control register, it acts as a single holding register.

The deserializer presents each finished byte with a one-cycle valid strobe, or a one-cycle break strobe when it sees a line break. The bus side issues one-cycle read strobes and gets the byte on the following cycle. A neighbouring interrupt encoder uses the data-ready, break, threshold, timeout and overrun outputs together with the retained control bits. The character time is derived from a four-bit line-format input and a baud tick that runs at sixteen ticks per bit.

Top module: `uart_rx_queue`

## Requirements
- R1: With control bit 0 set, the queue holds up to 16 bytes and returns them in arrival order; `level` reports the number held. With bit 0 clear it holds one byte.
- R2: With the queue enabled, `trig_hit` is high when `level` is at least the threshold chosen by control bits 7:6 (00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14); with the queue disabled, it follows `data_ready`.
- R3: A control write whose bit 0 differs from the retained bit 0 empties the receive queue and raises `txq_flush` for exactly one cycle, whatever bits 1 and 2 hold.
- R4: A control write differing from the retained value keeps only bits 7, 6, 3 and 0 in `ctl_q`; its bit 1 empties the receive queue and clears the timeout, its bit 2 pulses `txq_flush`. A write equal to `ctl_q` changes nothing. A flush takes precedence over a receive or read in the same cycle.
- R5: With the queue enabled, each accepted byte restarts a timer; after 64 times the frame length baud ticks with no further byte or read and data still held, `tmo_pend` rises. It never rises with the queue disabled.
- R6: A read clears `tmo_pend`. A read that leaves bytes behind restarts the timer; a read that empties the queue clears `data_ready` and `brk_ind`.
- R7: A break strobe stores a 0x00 byte and sets `brk_ind` and `data_ready`.
- R8: A read of an empty queue returns 0x00 on `rd_data` and leaves `level` at zero.
- R9: A byte arriving while the queue is full (16 enabled, 1 disabled) with no read in the same cycle is dropped and sets the sticky `overrun` flag, which a receive flush clears.
- R10: The frame length is 1 start bit, plus 5 to 8 data bits given by `line_fmt[1:0]`+5, plus one parity bit when `line_fmt[3]` is set, plus two stop bits when `line_fmt[2]` is set and one otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Line break strobe |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_data | input | 8 | Control register write value |
| line_fmt | input | 4 | Frame format: data length, stop bits, parity enable |
| baud_tick | input | 1 | Sixteen-per-bit baud tick |
| rd_en | input | 1 | Data read strobe |
| rd_data | output | 8 | Byte returned one cycle after a read |
| level | output | 5 | Number of bytes held |
| data_ready | output | 1 | At least one byte held |
| brk_ind | output | 1 | Break seen and not yet drained |
| trig_hit | output | 1 | Fill threshold reached |
| tmo_pend | output | 1 | Character timeout pending |
| overrun | output | 1 | A byte was dropped on a full queue |
| ctl_q | output | 8 | Retained control bits |
| txq_flush | output | 1 | One-cycle transmit queue flush request |

## Verification
The bound checker watches, on every cycle, the occupancy bound, the flush after an enable toggle, the tie between a pending timeout and held data, the clearing of the timeout by any read, the effect of a break strobe, a dropped byte on a full queue and the zero returned by an empty read. Only the bench scenarios can show the arrival order of the data, the threshold for each of the four encodings, the exact expiry cycle for all sixteen line formats, the timer restart on a partial read, the retention mask and the equal-write case, since these depend on sequences of many cycles and on computed counts.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  localparam int MAX_FRAME = 12;
  localparam logic [7:0] CTL_KEEP = 8'hC9;

  typedef enum logic [1:0] {
    TRIG_1  = 2'b00,
    TRIG_4  = 2'b01,
    TRIG_8  = 2'b10,
    TRIG_14 = 2'b11
  } trig_sel_e;

  function automatic logic [4:0] trig_bytes(input logic [1:0] sel);
    case (trig_sel_e'(sel))
      TRIG_1:  return 5'd1;
      TRIG_4:  return 5'd4;
      TRIG_8:  return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

  // start + data + optional parity + stop
  function automatic logic [3:0] frame_bits(input logic [3:0] fmt);
    return 4'd1 + (4'd5 + {2'b00, fmt[1:0]}) + {3'b000, fmt[3]} + (fmt[2] ? 4'd2 : 4'd1);
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  input  logic          rd_ok,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] count
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] head, tail;

  always_ff @(posedge clk) begin
    if (wr_en) mem[head] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_req) begin
      rd_data <= rd_ok ? mem[tail] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (wr_en) head <= head + 1'b1;
      if (rd_ok) tail <= tail + 1'b1;
      count <= count + CW'(wr_en) - CW'(rd_ok);
    end
  end

endmodule

// File: rtl/rxq_chartime.sv
module rxq_chartime
  import uart_rxq_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int TMO_CHARS     = 4,
  localparam int TW = $clog2(MAX_FRAME * TICKS_PER_BIT * TMO_CHARS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    fmt,
  output logic [TW-1:0] limit
);

  localparam int PER_FRAME_BIT = TICKS_PER_BIT * TMO_CHARS;

  always_ff @(posedge clk) begin
    if (rst) limit <= TW'(7 * PER_FRAME_BIT);
    else     limit <= TW'(frame_bits(fmt)) * TW'(PER_FRAME_BIT);
  end

endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          cancel,
  input  logic          clear,
  input  logic          tick,
  input  logic          has_data,
  input  logic [TW-1:0] limit,
  output logic          pend
);

  logic          armed;
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cnt   <= '0;
      pend  <= 1'b0;
    end else begin
      if (clear) pend <= 1'b0;
      if (cancel) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else if (restart) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (armed && tick) begin
        if (cnt == limit - 1'b1) begin
          armed <= 1'b0;
          cnt   <= '0;
          if (has_data && !clear) pend <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import uart_rxq_pkg::*;
#(
  parameter int DW            = 8,
  parameter int DEPTH         = 16,
  parameter int TICKS_PER_BIT = 16,
  parameter int TMO_CHARS     = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1,
  localparam int TW = $clog2(MAX_FRAME * TICKS_PER_BIT * TMO_CHARS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_break,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_data,
  input  logic [3:0]    line_fmt,
  input  logic          baud_tick,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] level,
  output logic          data_ready,
  output logic          brk_ind,
  output logic          trig_hit,
  output logic          tmo_pend,
  output logic          overrun,
  output logic [7:0]    ctl_q,
  output logic          txq_flush
);

  logic          fifo_on, ctl_change, en_toggle, rx_clr, tx_clr;
  logic          pop_ok, in_req, full_eff, push_ok;
  logic [CW-1:0] cap, lvl_next;
  logic [DW-1:0] in_byte;
  logic [TW-1:0] limit;
  logic          tm_restart, tm_cancel, tm_clear;
  logic          brk_q, ovr_q, txf_q;

  assign fifo_on    = ctl_q[0];
  assign ctl_change = ctl_wr && (ctl_data != ctl_q);
  assign en_toggle  = ctl_data[0] ^ ctl_q[0];
  assign rx_clr     = ctl_change && (ctl_data[1] || en_toggle);
  assign tx_clr     = ctl_change && (ctl_data[2] || en_toggle);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      txf_q <= 1'b0;
    end else begin
      txf_q <= tx_clr;
      if (ctl_change) ctl_q <= ctl_data & CTL_KEEP;
    end
  end

  assign cap      = fifo_on ? CW'(DEPTH) : CW'(1);
  assign pop_ok   = rd_en && !rx_clr && (level != '0);
  assign full_eff = (level >= cap) && !pop_ok;
  assign in_req   = (rx_valid || rx_break) && !rx_clr;
  assign push_ok  = in_req && !full_eff;
  assign in_byte  = rx_break ? '0 : rx_data;
  assign lvl_next = level + CW'(push_ok) - CW'(pop_ok);

  rxq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst     (rst),
    .clr     (rx_clr),
    .wr_en   (push_ok),
    .wr_data (in_byte),
    .rd_req  (rd_en && !rx_clr),
    .rd_ok   (pop_ok),
    .rd_data (rd_data),
    .count   (level)
  );

  rxq_chartime #(.TICKS_PER_BIT(TICKS_PER_BIT), .TMO_CHARS(TMO_CHARS)) u_ctime (
    .clk   (clk),
    .rst   (rst),
    .fmt   (line_fmt),
    .limit (limit)
  );

  assign tm_restart = fifo_on && (push_ok || (pop_ok && lvl_next != '0));
  assign tm_cancel  = rx_clr || (pop_ok && lvl_next == '0);
  assign tm_clear   = rx_clr || rd_en;

  rxq_timeout #(.TW(TW)) u_tmo (
    .clk      (clk),
    .rst      (rst),
    .restart  (tm_restart),
    .cancel   (tm_cancel),
    .clear    (tm_clear),
    .tick     (baud_tick),
    .has_data (level != '0),
    .limit    (limit),
    .pend     (tmo_pend)
  );

  always_ff @(posedge clk) begin
    if (rst || rx_clr) begin
      brk_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (rx_break) brk_q <= 1'b1;
      else if (pop_ok && lvl_next == '0) brk_q <= 1'b0;
      if (in_req && full_eff) ovr_q <= 1'b1;
    end
  end

  assign brk_ind    = brk_q;
  assign overrun    = ovr_q;
  assign txq_flush  = txf_q;
  assign data_ready = (level != '0);
  assign trig_hit   = fifo_on ? (level >= CW'(trig_bytes(ctl_q[7:6]))) : (level != '0);

endmodule

// File: rtl/uart_rx_queue_chk.sv
module uart_rx_queue_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_valid,
  input logic          rx_break,
  input logic          ctl_wr,
  input logic [7:0]    ctl_data,
  input logic [7:0]    ctl_q,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic [CW-1:0] level,
  input logic          data_ready,
  input logic          brk_ind,
  input logic          tmo_pend,
  input logic          overrun,
  input logic          txq_flush
);

  AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH)); // R1

  AST_TOGGLE_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && (ctl_data[0] != ctl_q[0])) |=> (level == '0 && txq_flush)); // R3

  AST_TMO_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
    tmo_pend |-> data_ready); // R5

  AST_READ_CLEARS_TMO: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !tmo_pend); // R6

  AST_BREAK_MARKS: assert property (@(posedge clk) disable iff (rst)
    (rx_break && !ctl_wr && !rd_en) |=> (brk_ind && data_ready)); // R7

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !data_ready && !rx_valid && !rx_break && !ctl_wr) |=> (level == '0 && rd_data == '0)); // R8

  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_break && !ctl_wr && !rd_en && level == (ctl_q[0] ? CW'(DEPTH) : CW'(1)))
    |=> (overrun && $stable(level))); // R9

endmodule

bind uart_rx_queue uart_rx_queue_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (.*);

// File: tb/uart_rx_queue_tb.sv
module uart_rx_queue_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_break = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_data = '0;
  logic [3:0] line_fmt = '0;
  logic       baud_tick = 1'b1;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [4:0] level;
  logic       data_ready, brk_ind, trig_hit, tmo_pend, overrun, txq_flush;
  logic [7:0] ctl_q;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  uart_rx_queue u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    rx_data = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic brk_ev();
    rx_break = 1'b1;
    @(negedge clk);
    rx_break = 1'b0;
  endtask

  task automatic rd(output logic [7:0] d);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wctl(input logic [7:0] v);
    ctl_wr = 1'b1; ctl_data = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  function automatic int exp_limit(input logic [3:0] f);
    return 64 * (1 + 5 + int'(f[1:0]) + int'(f[3]) + (f[2] ? 2 : 1));
  endfunction

  function automatic int exp_trig(input int code);
    case (code)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  initial begin
    logic [7:0] d;
    int lim;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    check("R1 reset level", level, 0);
    check("R1 reset data_ready", data_ready, 0);
    check("R4 reset ctl_q", ctl_q, 0);
    check("R5 reset tmo", tmo_pend, 0);
    check("R7 reset brk", brk_ind, 0);
    check("R9 reset overrun", overrun, 0);

    // disabled queue: single holding byte
    push(8'h11);
    push(8'h22);
    check("R9 overrun single", overrun, 1);
    check("R1 single level", level, 1);
    check("R2 trig disabled", trig_hit, 1);
    repeat (900) @(negedge clk);
    check("R5 no timeout disabled", tmo_pend, 0);
    rd(d);
    check("R1 single data", d, 8'h11);
    check("R6 single empty", data_ready, 0);

    // enable toggle
    wctl(8'h01);
    check("R3 txq pulse", txq_flush, 1);
    check("R3 ctl_q", ctl_q, 8'h01);
    check("R9 overrun cleared", overrun, 0);
    @(negedge clk);
    check("R3 txq one cycle", txq_flush, 0);
    push(8'hA1); push(8'hA2); push(8'hA3);
    wctl(8'h01);
    check("R4 equal write level", level, 3);
    check("R4 equal write txq", txq_flush, 0);
    wctl(8'h00);
    check("R3 toggle off level", level, 0);
    check("R3 toggle off txq", txq_flush, 1);
    wctl(8'hFF);
    check("R4 retained bits", ctl_q, 8'hC9);
    check("R3 toggle on txq", txq_flush, 1);

    // threshold and ordering sweep
    for (int code = 0; code < 4; code++) begin
      wctl({code[1:0], 6'b000011});
      check("R4 clear on bit1", level, 0);
      for (int k = 1; k <= 16; k++) begin
        push(8'(code * 16 + k - 1));
        check("R1 level count", level, k);
        check("R2 trig level", trig_hit, (k >= exp_trig(code)) ? 1 : 0);
      end
      push(8'hEE);
      check("R9 overrun full", overrun, 1);
      check("R9 level held", level, 16);
      for (int k = 0; k < 16; k++) begin
        rd(d);
        check("R1 order", d, 8'(code * 16 + k));
      end
      check("R6 empty after drain", data_ready, 0);
      rd(d);
      check("R8 empty read data", d, 0);
      check("R8 empty read level", level, 0);
    end

    // timeout across all frame formats
    for (int f = 0; f < 16; f++) begin
      wctl(8'h03);
      line_fmt = 4'(f);
      repeat (2) @(negedge clk);
      lim = exp_limit(4'(f));
      push(8'h5A);
      repeat (lim - 1) @(negedge clk);
      check("R10 R5 before expiry", tmo_pend, 0);
      @(negedge clk);
      check("R10 R5 at expiry", tmo_pend, 1);
      rd(d);
      check("R6 read clears tmo", tmo_pend, 0);
      check("R6 read empties", data_ready, 0);
    end

    // restart on a read that leaves data
    wctl(8'h03);
    line_fmt = 4'h0;
    repeat (2) @(negedge clk);
    lim = exp_limit(4'h0);
    push(8'h01); push(8'h02);
    repeat (100) @(negedge clk);
    rd(d);
    repeat (lim - 1) @(negedge clk);
    check("R6 restart before", tmo_pend, 0);
    @(negedge clk);
    check("R6 restart expiry", tmo_pend, 1);
    rd(d);
    check("R6 last byte", d, 8'h02);
    check("R6 tmo cleared", tmo_pend, 0);

    // break handling
    wctl(8'h01);
    push(8'h55);
    brk_ev();
    check("R7 brk set", brk_ind, 1);
    check("R7 level", level, 2);
    rd(d);
    check("R7 data before break", d, 8'h55);
    check("R7 brk kept", brk_ind, 1);
    rd(d);
    check("R7 zero byte", d, 0);
    check("R6 brk cleared", brk_ind, 0);
    check("R6 dr cleared", data_ready, 0);

    // receive flush clears a pending timeout
    push(8'h77);
    repeat (lim) @(negedge clk);
    check("R5 pending", tmo_pend, 1);
    wctl(8'h03);
    check("R4 flush clears tmo", tmo_pend, 0);
    check("R4 flush level", level, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule